// File: doc/BRIEF.md
# Radio Power-Mode Sequencer

This block sequences a radio modem through its operating modes: Off, Hibernate, Doze, Idle, Receive and Transmit. It decides which mode the modem is in, when the reference oscillator, the serial control port and the divided clock output may run, and how long each change of mode takes. Every wake-up and turn-on delay is a parameter counted in reference clock cycles. While a timed change is under way the block shows busy and drops its ready flag.

The host asks for a mode with a one-cycle request strobe and a mode code. The sleep modes and the radio modes can be entered only from Idle. Only an external attention line can end Hibernate. Doze ends on attention or on a pulse from a wake timer. A Receive or Transmit operation ends when the end strobe is pulsed, whether the operation finished or was aborted. The attention line is asynchronous, and the block acts on its rising edge once that edge has passed a two-flop synchroniser.

Top module: `radio_pm_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to Off: `mode_o`=0, and `busy_o`, `ready_o`, `osc_en_o`, `spi_en_o`, `clko_oe_o` and `pin_drive_o` are all 0. `pin_drive_o` is 0 whenever the mode is Off.
- R2: At the first edge with `rst_n` high, the block starts its power-up. `busy_o` and `osc_en_o` rise, and exactly RST_CYC edges later `mode_o` becomes Idle (3) with `ready_o`=1 and `busy_o`=0.
- R3: A request for Hibernate (code 1) or Doze (code 2) takes effect at the next edge, but only when the block is settled in Idle. Requests of any code made in Hibernate, Doze, Receive or Transmit are ignored. In Idle, requests for Off (0), Idle (3) or codes 6 and 7 are also ignored.
- R4: In Hibernate, `osc_en_o`, `spi_en_o` and `clko_oe_o` are 0. Only a rising edge on `attn_i` ends Hibernate. That edge is acted on at the second edge after `attn_i` is first sampled high. Idle is then reached HIB_CYC edges later. `timer_hit_i`, requests and `op_end_i` have no effect in Hibernate.
- R5: In Doze the oscillator stays on and the serial port is off. Either an attention rising edge or `timer_hit_i` starts the return to Idle, which takes DOZE_CYC plus one clock-output period. The period is taken from `clko_sel_i` when the return starts: selects 0 to 4 give 1, 2, 4, 8 and 16 cycles, and selects 5, 6 and 7 give 256, 488 and 976 cycles.
- R6: In Idle, Receive and Transmit, `clko_oe_o` equals `clko_en_i`. In Doze it is `clko_en_i` only when `clko_sel_i` ≥ 4, which is an output of 1 MHz or slower; otherwise it is 0. In Off and Hibernate it is 0.
- R7: A request for Receive (4) or Transmit (5) made in settled Idle is accepted at that edge, and the mode changes TURN_CYC edges later. `mode_o` shows Idle until then.
- R8: A pulse on `op_end_i` in settled Receive or Transmit returns the block to Idle at that same edge. In other modes `op_end_i` has no effect.
- R9: While `busy_o` is 1, requests, attention edges, timer pulses and end strobes are all ignored and `ready_o` is 0.
- R10: `spi_en_o` is 1 exactly when `mode_o` is Idle, Receive or Transmit. `osc_en_o` is 1 when busy or when the mode is Doze, Idle, Receive or Transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Modem reset, active low, synchronous |
| attn_i | input | 1 | Asynchronous attention wake line |
| timer_hit_i | input | 1 | Doze wake-timer compare pulse |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 3 | Requested mode code |
| op_end_i | input | 1 | Receive/Transmit finished or aborted |
| clko_en_i | input | 1 | Clock-output enable bit |
| clko_sel_i | input | 3 | Clock-output divider select |
| mode_o | output | 3 | Current settled mode code |
| busy_o | output | 1 | Timed transition in progress |
| ready_o | output | 1 | Settled in a mode other than Off |
| osc_en_o | output | 1 | Reference oscillator enable |
| spi_en_o | output | 1 | Serial control port enable |
| clko_oe_o | output | 1 | Clock-output enable |
| pin_drive_o | output | 1 | Interface pin drive enable (low = high impedance) |

## Verification
The bench builds the block with RST_CYC=20, HIB_CYC=12, DOZE_CYC=6 and TURN_CYC=5. These short delays mean every timed path, and the cycle on which each one ends, is reached within a few hundred cycles instead of hundreds of thousands. The Doze delay is short enough that the 256-cycle clock-output period is the larger share of one wake-up. This makes it clear that the block adds that period to the Doze delay. A second Doze wake-up with a small select shows the block takes the period from the select in force when the wake-up starts. Requests, end strobes, timer pulses and attention edges are sent both during the waits and in modes that must ignore them.

// File: rtl/pmc_pkg.sv
// Shared mode codes and the clock-output period helper.
// Assumes a reference clock that the divider select divides directly.
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_OFF   = 3'd0,
        PM_HIB   = 3'd1,
        PM_DOZE  = 3'd2,
        PM_IDLE  = 3'd3,
        PM_RX    = 3'd4,
        PM_TX    = 3'd5
    } pm_mode_e;

    // Select at or above which the clock output is slow enough for Doze.
    localparam logic [2:0] CLKO_SLOW_SEL = 3'd4;

    // Reference cycles in one clock-output period for a divider select.
    function automatic int unsigned clko_period(input logic [2:0] sel);
        int unsigned p;
        case (sel)
            3'd5:    p = 256;
            3'd6:    p = 488;
            3'd7:    p = 976;
            default: p = 32'd1 << sel;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pmc_attn_sync.sv
// Synchronises the asynchronous attention line and flags its rising edge.
// Assumes the line stays high for at least two reference cycles.
module pmc_attn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic attn_async,
    output logic attn_rise
);
    logic [STAGES:0] shreg;

    // Shift chain: STAGES synchroniser flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], attn_async};
    end

    assign attn_rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/pmc_delay_ctr.sv
// Down-counter that times one mode transition.
// Assumes load_val >= 1. done pulses on the last busy cycle.
module pmc_delay_ctr #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load_val,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Load on start, then count down to zero while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= load_val - CW'(1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - CW'(1);
        end
    end

    assign done = busy && (cnt == '0);
endmodule

// File: rtl/pmc_clko_gate.sv
// Decides whether the divided clock output may run in the present mode.
// Assumes mode is the settled mode from the sequencer.
module pmc_clko_gate
    import pmc_pkg::*;
(
    input  pm_mode_e   mode,
    input  logic       en_bit,
    input  logic [2:0] sel,
    output logic       oe
);
    // Mode-dependent gating of the enable bit.
    always_comb begin
        case (mode)
            PM_IDLE, PM_RX, PM_TX: oe = en_bit;
            PM_DOZE:               oe = en_bit && (sel >= CLKO_SLOW_SEL);
            default:               oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/radio_pm_ctrl.sv
// Power-mode sequencer for a radio modem: accepts mode requests, wake
// events and operation-end strobes, times every transition in reference
// cycles and drives oscillator, serial port and clock-output enables.
// Assumes single-cycle strobes and a synchronous active-low reset.
module radio_pm_ctrl
    import pmc_pkg::*;
#(
    parameter int RST_CYC  = 160000,
    parameter int HIB_CYC  = 112000,
    parameter int DOZE_CYC = 4800,
    parameter int TURN_CYC = 2304
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       attn_i,
    input  logic       timer_hit_i,
    input  logic       req_valid_i,
    input  logic [2:0] req_mode_i,
    input  logic       op_end_i,
    input  logic       clko_en_i,
    input  logic [2:0] clko_sel_i,
    output logic [2:0] mode_o,
    output logic       busy_o,
    output logic       ready_o,
    output logic       osc_en_o,
    output logic       spi_en_o,
    output logic       clko_oe_o,
    output logic       pin_drive_o
);
    localparam int MAX_A   = (RST_CYC > HIB_CYC) ? RST_CYC : HIB_CYC;
    localparam int MAX_B   = (DOZE_CYC + 976 > TURN_CYC) ? DOZE_CYC + 976 : TURN_CYC;
    localparam int MAX_DLY = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(MAX_DLY + 1);

    pm_mode_e      mode_q, tgt_q, tgt_d, imm_tgt;
    logic          start, imm_go, busy, done, attn_rise;
    logic [CW-1:0] load_val;
    pm_mode_e      req_code;

    assign req_code = pm_mode_e'(req_mode_i);

    pmc_attn_sync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .attn_async (attn_i),
        .attn_rise  (attn_rise)
    );

    pmc_delay_ctr #(.CW(CW)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load_val (load_val),
        .busy     (busy),
        .done     (done)
    );

    pmc_clko_gate u_clko (
        .mode   (mode_q),
        .en_bit (clko_en_i),
        .sel    (clko_sel_i),
        .oe     (clko_oe_o)
    );

    // Choose a timed or immediate transition from the settled mode.
    always_comb begin
        start    = 1'b0;
        imm_go   = 1'b0;
        imm_tgt  = PM_IDLE;
        tgt_d    = PM_IDLE;
        load_val = CW'(1);
        if (!busy) begin
            case (mode_q)
                PM_OFF: begin
                    start    = 1'b1;
                    load_val = CW'(RST_CYC);
                end
                PM_IDLE: begin
                    if (req_valid_i) begin
                        case (req_code)
                            PM_HIB, PM_DOZE: begin
                                imm_go  = 1'b1;
                                imm_tgt = req_code;
                            end
                            PM_RX, PM_TX: begin
                                start    = 1'b1;
                                tgt_d    = req_code;
                                load_val = CW'(TURN_CYC);
                            end
                            default: ;
                        endcase
                    end
                end
                PM_HIB: begin
                    if (attn_rise) begin
                        start    = 1'b1;
                        load_val = CW'(HIB_CYC);
                    end
                end
                PM_DOZE: begin
                    if (attn_rise || timer_hit_i) begin
                        start    = 1'b1;
                        load_val = CW'(DOZE_CYC) + CW'(clko_period(clko_sel_i));
                    end
                end
                PM_RX, PM_TX: begin
                    if (op_end_i) imm_go = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Mode register: settle on counter completion or take an immediate move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_OFF;
            tgt_q  <= PM_IDLE;
        end else begin
            if (start) tgt_q <= tgt_d;
            if (done)        mode_q <= tgt_q;
            else if (imm_go) mode_q <= imm_tgt;
        end
    end

    assign mode_o      = mode_q;
    assign busy_o      = busy;
    assign ready_o     = !busy && (mode_q != PM_OFF);
    assign spi_en_o    = (mode_q == PM_IDLE) || (mode_q == PM_RX) || (mode_q == PM_TX);
    assign osc_en_o    = busy || (mode_q == PM_DOZE) || spi_en_o;
    assign pin_drive_o = (mode_q != PM_OFF);
endmodule

// File: rtl/pmc_checker.sv
// Temporal checks on the sequencer's ports, bound into every instance.
module pmc_checker
    import pmc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_end_i,
    input logic [2:0] clko_sel_i,
    input logic [2:0] mode_o,
    input logic       busy_o,
    input logic       ready_o,
    input logic       clko_oe_o
);
    AST_SLEEP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_o) && (mode_o == PM_HIB || mode_o == PM_DOZE)) |-> ($past(mode_o) == PM_IDLE)); // R3

    AST_HIB_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == PM_HIB) |=> (mode_o == PM_HIB || mode_o == PM_IDLE)); // R4

    AST_OP_END_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == PM_RX || mode_o == PM_TX) && !busy_o && op_end_i) |=> (mode_o == PM_IDLE)); // R8

    AST_BUSY_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mode_o)); // R9

    AST_SETTLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (ready_o && mode_o != PM_OFF)); // R2

    AST_DOZE_FAST_CLKO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == PM_DOZE && clko_sel_i < CLKO_SLOW_SEL) |-> !clko_oe_o); // R6
endmodule

bind radio_pm_ctrl pmc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_end_i   (op_end_i),
    .clko_sel_i (clko_sel_i),
    .mode_o     (mode_o),
    .busy_o     (busy_o),
    .ready_o    (ready_o),
    .clko_oe_o  (clko_oe_o)
);

// File: tb/sim_radio_pm_ctrl.sv
// Bench: behavioural reference model compared with the design every cycle.
module sim_radio_pm_ctrl;
    localparam int CLK_P = 10;
    localparam int P_RST = 20, P_HIB = 12, P_DOZE = 6, P_TURN = 5;

    logic clk = 1'b0, rst_n = 1'b0, attn = 1'b0, thit = 1'b0;
    logic rv = 1'b0, oend = 1'b0, cen = 1'b0;
    logic [2:0] rmode = 3'd0, csel = 3'd0;
    logic [2:0] mode_o;
    logic busy_o, ready_o, osc_o, spi_o, clko_o, pin_o;

    int checks = 0, bad = 0, cycles = 0;
    string phase = "R1";

    always #(CLK_P/2) clk = ~clk;

    radio_pm_ctrl #(.RST_CYC(P_RST), .HIB_CYC(P_HIB), .DOZE_CYC(P_DOZE), .TURN_CYC(P_TURN)) u0 (
        .clk(clk), .rst_n(rst_n), .attn_i(attn), .timer_hit_i(thit),
        .req_valid_i(rv), .req_mode_i(rmode), .op_end_i(oend),
        .clko_en_i(cen), .clko_sel_i(csel), .mode_o(mode_o), .busy_o(busy_o),
        .ready_o(ready_o), .osc_en_o(osc_o), .spi_en_o(spi_o),
        .clko_oe_o(clko_o), .pin_drive_o(pin_o)
    );

    // Reference model state: mode codes 0 Off,1 Hib,2 Doze,3 Idle,4 Rx,5 Tx.
    int m_mode = 0, m_tgt = 3, m_rem = 0;
    bit m_busy = 0;
    bit attn_q[$] = '{0, 0, 0};

    function automatic int per(input int s);
        if (s == 5) return 256;
        if (s == 6) return 488;
        if (s == 7) return 976;
        return 2 ** s;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit rise;
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_busy = 0; m_rem = 0;
            attn_q = '{0, 0, 0};
        end else begin
            rise = attn_q[1] && !attn_q[2];
            if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin m_busy = 0; m_mode = m_tgt; end
            end else if (m_mode == 0) begin
                m_busy = 1; m_rem = P_RST; m_tgt = 3;
            end else if (m_mode == 3 && rv) begin
                if (rmode == 1 || rmode == 2) m_mode = rmode;
                else if (rmode == 4 || rmode == 5) begin m_busy = 1; m_rem = P_TURN; m_tgt = rmode; end
            end else if (m_mode == 1 && rise) begin
                m_busy = 1; m_rem = P_HIB; m_tgt = 3;
            end else if (m_mode == 2 && (rise || thit)) begin
                m_busy = 1; m_rem = P_DOZE + per(csel); m_tgt = 3;
            end else if ((m_mode == 4 || m_mode == 5) && oend) begin
                m_mode = 3;
            end
            void'(attn_q.pop_back());
            attn_q.push_front(attn);
        end
        #(CLK_P/4);
        begin
            bit active, exp_clko;
            active = (m_mode >= 3);
            exp_clko = active ? cen : (m_mode == 2) ? (cen && csel >= 4) : 1'b0;
            chk(phase, "mode", mode_o, m_mode);
            chk(phase, "busy", busy_o, m_busy);
            chk(phase, "ready", ready_o, (!m_busy && m_mode != 0));
            chk("R10", "osc_en", osc_o, (m_busy || m_mode >= 2));
            chk("R10", "spi_en", spi_o, active);
            chk("R6", "clko_oe", clko_o, exp_clko);
            chk("R1", "pin_drive", pin_o, (m_mode != 0));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req(input int code);
        rv = 1'b1; rmode = 3'(code); cyc(1); rv = 1'b0;
    endtask

    task automatic pulse_end();
        oend = 1'b1; cyc(1); oend = 1'b0;
    endtask

    task automatic pulse_timer();
        thit = 1'b1; cyc(1); thit = 1'b0;
    endtask

    task automatic pulse_attn();
        attn = 1'b1; cyc(3); attn = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        wait (cycles > 20000);
        bad++; checks++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        cen = 1'b1; csel = 3'd2;
        phase = "R1"; cyc(5);
        @(negedge clk); rst_n = 1'b1;
        phase = "R2"; cyc(3);
        phase = "R9"; req(4); pulse_end(); pulse_attn();
        phase = "R2"; cyc(P_RST);
        phase = "R3"; req(0); req(3); req(7); cyc(2);
        req(1); cyc(2);
        phase = "R4"; req(2); pulse_timer(); pulse_end(); req(3); cyc(3);
        pulse_attn(); cyc(P_HIB + 3);
        phase = "R6"; csel = 3'd2; req(2); cyc(4); csel = 3'd5; cyc(4);
        phase = "R5"; pulse_timer(); cyc(5);
        phase = "R9"; pulse_attn(); req(1);
        phase = "R5"; cyc(P_DOZE + 256);
        csel = 3'd1; req(2); cyc(3); req(4); pulse_attn(); cyc(P_DOZE + 6);
        phase = "R7"; req(4); cyc(1);
        phase = "R9"; req(5); pulse_end(); cyc(P_TURN);
        phase = "R3"; req(1); req(2); cyc(2);
        phase = "R8"; pulse_end(); cyc(2);
        phase = "R7"; req(5); cyc(P_TURN + 2);
        phase = "R6"; cen = 1'b0; cyc(2); cen = 1'b1;
        phase = "R8"; pulse_end(); cyc(2);
        phase = "R1"; rst_n = 1'b0; cyc(4);
        rst_n = 1'b1;
        phase = "R2"; cyc(P_RST + 4);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule